// File: doc/BRIEF.md
# Data Watchpoint Matcher

This block watches the data-access bus of a processor core and reports every access that touches a memory region a debugger has asked to watch. It has four independent slots. Each slot holds a base address, a region length of one, two or four bytes, an access condition and an enable flag. The condition is either "writes only" or "reads and writes". There is no reads-only condition.

On every valid access, the block compares the accessed byte range with the region of each enabled slot. A slot that matches sets its own sticky bit in a status vector. The trap output rises for one cycle whenever an access sets at least one status bit that was clear before. The status says which slots matched. It does not say which byte inside a slot's region was touched.

A single configuration write port programs one slot at a time. The same port clears status bits by writing zeros to them.

Top module: `dbg_watch_unit`

## Requirements
- R1: When `rst_n` is low at a clock edge, `hit_status` becomes 0, `trap` becomes 0 and every slot is disabled. After reset, no access can set a status bit until a slot is programmed.
- R2: The length code `cfg_len` sets the size of a slot's region: 2'b00 is 1 byte, 2'b01 is 2 bytes and 2'b11 is 4 bytes. The code 2'b10 is reserved, and a slot programmed with it never matches.
- R3: The region of a slot starts at the programmed address rounded down to a multiple of its length. Address bits below the length are ignored when comparing.
- R4: An access covers the bytes [`acc_addr`, `acc_addr` + 2^`acc_size`), so `acc_size` 0/1/2/3 means 1/2/4/8 bytes. An access matches a slot when its byte range overlaps the slot's region by at least one byte.
- R5: When `cfg_wonly`=1, the slot matches only accesses with `acc_write`=1. When `cfg_wonly`=0, the slot matches both reads and writes.
- R6: A slot whose enable bit is 0 never sets its status bit.
- R7: A valid, matching access sets bit k of `hit_status` at the clock edge that samples the access, for every matching slot k in the same cycle. A set bit stays set until it is cleared as in R8. `hit_status` changes only on a valid access or a status write.
- R8: A configuration write with `cfg_sel`=4 clears every status bit whose `cfg_keep` bit is 0 and leaves the other bits as they are. If an access matches slot k in the same cycle, bit k is set anyway.
- R9: `trap` is high for exactly the one cycle after an access that sets at least one status bit that was 0. An access that matches only slots whose bits are already set does not raise `trap`.
- R10: A configuration write with `cfg_sel`=k (0..3) loads slot k. That slot's new settings apply from the next cycle on. An access in the same cycle as the write is compared with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target: 0..3 selects a slot, 4 selects the status vector |
| cfg_addr | input | 32 | Slot base address |
| cfg_len | input | 2 | Slot length code |
| cfg_wonly | input | 1 | 1 = match writes only, 0 = match reads and writes |
| cfg_en | input | 1 | Slot enable |
| cfg_keep | input | 4 | Status write mask; a 0 bit clears that status bit |
| acc_valid | input | 1 | A data access is present this cycle |
| acc_addr | input | 32 | Lowest byte address of the access |
| acc_size | input | 2 | log2 of the access size in bytes |
| acc_write | input | 1 | 1 = write, 0 = read |
| hit_status | output | 4 | Sticky per-slot hit bits |
| trap | output | 1 | One-cycle pulse on any new hit |

## Verification
The bench probes byte ranges that stop exactly one byte short of a region, and ranges that straddle a region edge from below or above. A comparator with an off-by-one end bound, or one that tests only the start address, would miss the straddles or report the neighbours. Programmed addresses that are not aligned check that the low bits are masked; the reserved length code and the write-only slots probed with reads catch a decoder that lets either match. Repeated hits on an already-set bit, a clear that coincides with a hit, and a reprogram in the same cycle as an access expose a trap that fires on every match, a clear that beats a set, and a configuration that takes effect one cycle early.

// File: rtl/dbg_watch_pkg.sv
// Package: dbg_watch_pkg
// Shared encodings for the watchpoint matcher: the slot length code and
// helpers that turn codes into byte counts. It assumes regions are 1, 2 or
// 4 bytes and accesses are 1 to 8 bytes.
package dbg_watch_pkg;

    typedef enum logic [1:0] {
        LEN_1B   = 2'b00,
        LEN_2B   = 2'b01,
        LEN_RSVD = 2'b10,
        LEN_4B   = 2'b11
    } wlen_e;

    typedef struct packed {
        logic  en;
        logic  wonly;
        wlen_e len;
    } slot_ctl_t;

    // Region size in bytes for a length code; the reserved code gives 0
    function automatic logic [2:0] region_bytes(wlen_e code);
        case (code)
            LEN_1B:  return 3'd1;
            LEN_2B:  return 3'd2;
            LEN_4B:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // Access size in bytes for a log2 size code
    function automatic logic [3:0] access_bytes(logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/dbg_watch_cmp.sv
// Module: dbg_watch_cmp
// Combinational range comparator. It aligns the slot base down to the region
// length and reports whether the access byte range overlaps that region.
// Both ends are computed one bit wider than the address, so a range that
// runs past the top of the address space does not wrap around to zero.
// A reserved length code never reports an overlap.
module dbg_watch_cmp
    import dbg_watch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  wlen_e             len_code,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              overlap
);

    localparam int EXT_W = ADDR_W + 1;

    logic [2:0]        nbytes;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] base_aligned;
    logic [EXT_W-1:0]  slot_lo;
    logic [EXT_W-1:0]  slot_hi;
    logic [EXT_W-1:0]  acc_lo;
    logic [EXT_W-1:0]  acc_hi;

    // Align the base address to the region length
    always_comb begin
        nbytes       = region_bytes(len_code);
        low_mask     = (nbytes == 3'd0) ? '0 : ADDR_W'(nbytes - 3'd1);
        base_aligned = base_addr & ~low_mask;
    end

    // Half-open intervals: [lo, hi), computed without wrap
    always_comb begin
        slot_lo = {1'b0, base_aligned};
        slot_hi = slot_lo + EXT_W'(nbytes);
        acc_lo  = {1'b0, acc_addr};
        acc_hi  = acc_lo + EXT_W'(access_bytes(acc_size));
    end

    // Two ranges overlap when each one starts before the other one ends
    always_comb begin
        overlap = (nbytes != 3'd0) && (acc_lo < slot_hi) && (slot_lo < acc_hi);
    end

endmodule

// File: rtl/dbg_watch_slot.sv
// Module: dbg_watch_slot
// One watchpoint slot. It holds the base address, length code, condition and
// enable, loaded by a configuration write addressed to SLOT_ID, and reports a
// combinational hit for the current access. It assumes the settings loaded
// by a write take effect only on the following cycle.
module dbg_watch_slot
    import dbg_watch_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 3,
    parameter int SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_wonly,
    input  logic              cfg_en,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    output logic              hit,
    output logic              slot_en,
    output logic              slot_wonly
);

    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(SLOT_ID);

    logic [ADDR_W-1:0] base_q;
    slot_ctl_t         ctl_q;
    logic              load;
    logic              range_ok;
    logic              type_ok;

    // Decode a configuration write aimed at this slot
    assign load = cfg_wr && (cfg_sel == MY_SEL);

    // Slot settings register; reset leaves the slot disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ctl_q  <= '{en: 1'b0, wonly: 1'b0, len: LEN_1B};
        end else if (load) begin
            base_q <= cfg_addr;
            ctl_q  <= '{en: cfg_en, wonly: cfg_wonly, len: wlen_e'(cfg_len)};
        end
    end

    // Byte-range comparison against the aligned region
    dbg_watch_cmp #(
        .ADDR_W (ADDR_W)
    ) u_cmp (
        .base_addr (base_q),
        .len_code  (ctl_q.len),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .overlap   (range_ok)
    );

    // Access condition: writes always qualify, reads only when not write-only
    assign type_ok = acc_write || !ctl_q.wonly;

    // Final per-slot hit for this cycle
    assign hit = acc_valid && ctl_q.en && type_ok && range_ok;

    assign slot_en    = ctl_q.en;
    assign slot_wonly = ctl_q.wonly;

endmodule

// File: rtl/dbg_watch_status.sv
// Module: dbg_watch_status
// Sticky hit vector and trap pulse. Bits are set by slot hits and cleared by
// a status write with zeros in the keep mask; a set in the same cycle wins.
// The trap is registered and marks a cycle in which a clear bit became set.
module dbg_watch_status #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_wr,
    input  logic [NUM_SLOTS-1:0] keep,
    input  logic [NUM_SLOTS-1:0] match,
    output logic [NUM_SLOTS-1:0] status,
    output logic                 trap
);

    logic [NUM_SLOTS-1:0] fresh;
    logic [NUM_SLOTS-1:0] kept;

    // Bits that are set by this access and were clear before it
    assign fresh = match & ~status;

    // Bits left after an optional clear
    assign kept = clr_wr ? (status & keep) : status;

    // Sticky status update with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= kept | match;
        end
    end

    // One-cycle trap on any newly set bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap <= 1'b0;
        end else begin
            trap <= |fresh;
        end
    end

endmodule

// File: rtl/dbg_watch_unit.sv
// Module: dbg_watch_unit
// Top of the data watchpoint matcher. It instantiates NUM_SLOTS slots and the
// sticky status logic. Select values 0..NUM_SLOTS-1 address slots and the
// value NUM_SLOTS addresses the status vector. It assumes one access at most
// per cycle.
module dbg_watch_unit #(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 4,
    parameter int SEL_W     = $clog2(NUM_SLOTS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [1:0]           cfg_len,
    input  logic                 cfg_wonly,
    input  logic                 cfg_en,
    input  logic [NUM_SLOTS-1:0] cfg_keep,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [1:0]           acc_size,
    input  logic                 acc_write,
    output logic [NUM_SLOTS-1:0] hit_status,
    output logic                 trap
);

    localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_SLOTS);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic [NUM_SLOTS-1:0] slot_en_vec;
    logic [NUM_SLOTS-1:0] slot_wonly_vec;
    logic                 status_wr;

    // One slot per index, each decoding its own select value
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        dbg_watch_slot #(
            .ADDR_W  (ADDR_W),
            .SEL_W   (SEL_W),
            .SLOT_ID (k)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_wr     (cfg_wr),
            .cfg_sel    (cfg_sel),
            .cfg_addr   (cfg_addr),
            .cfg_len    (cfg_len),
            .cfg_wonly  (cfg_wonly),
            .cfg_en     (cfg_en),
            .acc_valid  (acc_valid),
            .acc_addr   (acc_addr),
            .acc_size   (acc_size),
            .acc_write  (acc_write),
            .hit        (slot_hit[k]),
            .slot_en    (slot_en_vec[k]),
            .slot_wonly (slot_wonly_vec[k])
        );
    end

    // Status write decode
    assign status_wr = cfg_wr && (cfg_sel == STATUS_SEL);

    // Sticky status and trap generation
    dbg_watch_status #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_wr (status_wr),
        .keep   (cfg_keep),
        .match  (slot_hit),
        .status (hit_status),
        .trap   (trap)
    );

endmodule

// File: rtl/dbg_watch_checker.sv
// Module: dbg_watch_checker
// Temporal checks on the matcher's ports and slot state, bound to the top.
module dbg_watch_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int SEL_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [NUM_SLOTS-1:0] cfg_keep,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic [NUM_SLOTS-1:0] slot_wonly,
    input  logic [NUM_SLOTS-1:0] hit_status,
    input  logic                 trap
);

    localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_SLOTS);

    logic past_rst_valid;

    // Track that at least one clock edge has been seen
    always_ff @(posedge clk) past_rst_valid <= 1'b1;

    // R1: the cycle after reset is asserted, status and trap are clear
    a_r1_reset_clear: assert property (@(posedge clk)
        past_rst_valid && $past(!rst_n) |-> (hit_status == '0) && !trap);

    // R7: without an access, no status bit rises
    a_r7_no_set_without_access: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (hit_status & ~$past(hit_status)) == '0);

    // R7: without a status write, set bits stay set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_sel == STATUS_SEL) |=> (hit_status & $past(hit_status)) == $past(hit_status));

    // R6: with every slot disabled, no status bit rises
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (slot_en == '0) |=> (hit_status & ~$past(hit_status)) == '0);

    // R5: a read cannot hit when every enabled slot is write-only
    a_r5_read_vs_wonly: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && ((slot_en & ~slot_wonly) == '0)
        |=> (hit_status & ~$past(hit_status)) == '0);

    // R8: a clear with no access leaves exactly the kept bits
    a_r8_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && (cfg_sel == STATUS_SEL) && !acc_valid
        |=> hit_status == ($past(hit_status) & $past(cfg_keep)));

    // R9: trap is high exactly when a status bit has newly risen
    a_r9_trap_on_new: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (hit_status & ~$past(hit_status)) != '0);

    a_r9_new_gives_trap: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_status & ~$past(hit_status)) != '0) |-> trap);

endmodule

bind dbg_watch_unit dbg_watch_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .SEL_W     (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_keep   (cfg_keep),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .slot_en    (slot_en_vec),
    .slot_wonly (slot_wonly_vec),
    .hit_status (hit_status),
    .trap       (trap)
);

// File: tb/dbg_watch_unit_tb.sv
`timescale 1ns/1ps
// Bench for dbg_watch_unit: a vector table of accesses against a fixed slot
// setup, followed by directed tests for reset and corner cases.
module dbg_watch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_addr = '0;
    logic [1:0]  cfg_len = '0;
    logic        cfg_wonly = 1'b0;
    logic        cfg_en = 1'b0;
    logic [3:0]  cfg_keep = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic [3:0]  hit_status;
    logic        trap;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbg_watch_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_addr   (cfg_addr),
        .cfg_len    (cfg_len),
        .cfg_wonly  (cfg_wonly),
        .cfg_en     (cfg_en),
        .cfg_keep   (cfg_keep),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_size   (acc_size),
        .acc_write  (acc_write),
        .hit_status (hit_status),
        .trap       (trap)
    );

    // Vector: {address, size code, write, expected status after a clear}
    // Slots: 0 = 0x1000 4B rw, 1 = 0x1006 2B wo, 2 = 0x2003 1B rw,
    // 3 = 0x3001 programmed with 4B wo (aligned region 0x3000..0x3003)
    localparam int NVEC = 18;
    localparam logic [38:0] VEC [NVEC] = '{
        {32'h0000_1000, 2'd0, 1'b0, 4'b0001},
        {32'h0000_1003, 2'd0, 1'b1, 4'b0001},
        {32'h0000_1004, 2'd0, 1'b0, 4'b0000},
        {32'h0000_1002, 2'd2, 1'b1, 4'b0001},
        {32'h0000_1004, 2'd2, 1'b1, 4'b0010},
        {32'h0000_1004, 2'd2, 1'b0, 4'b0000},
        {32'h0000_1000, 2'd3, 1'b1, 4'b0011},
        {32'h0000_0FFF, 2'd1, 1'b0, 4'b0001},
        {32'h0000_0FFC, 2'd2, 1'b1, 4'b0000},
        {32'h0000_2003, 2'd0, 1'b0, 4'b0100},
        {32'h0000_2002, 2'd0, 1'b1, 4'b0000},
        {32'h0000_2004, 2'd0, 1'b1, 4'b0000},
        {32'h0000_2000, 2'd2, 1'b0, 4'b0100},
        {32'h0000_3003, 2'd0, 1'b1, 4'b1000},
        {32'h0000_3000, 2'd0, 1'b0, 4'b0000},
        {32'h0000_3004, 2'd0, 1'b1, 4'b0000},
        {32'h0000_1006, 2'd0, 1'b1, 4'b0010},
        {32'h0000_1008, 2'd0, 1'b1, 4'b0000}
    };

    // Compare one value and report a failure
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Load one slot
    task automatic prog_slot(input int idx, input logic [31:0] a, input logic [1:0] len,
                             input logic wo, input logic en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'(idx); cfg_addr = a;
        cfg_len = len; cfg_wonly = wo; cfg_en = en;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Status write with a keep mask
    task automatic clear_status(input logic [3:0] keep);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'd4; cfg_keep = keep;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One-cycle access; returns just after the edge that samples it
    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status after reset", 32'(hit_status), 32'h0);
        check("R1 trap after reset", 32'(trap), 32'h0);
        rst_n = 1'b1;
        // R1/R6: slots start disabled, so nothing matches
        access(32'h0000_0000, 2'd3, 1'b1);
        check("R1 no hit before programming", 32'(hit_status), 32'h0);
        check("R1 no trap before programming", 32'(trap), 32'h0);

        // Table setup
        prog_slot(0, 32'h0000_1000, 2'b11, 1'b0, 1'b1);
        prog_slot(1, 32'h0000_1006, 2'b01, 1'b1, 1'b1);
        prog_slot(2, 32'h0000_2003, 2'b00, 1'b0, 1'b1);
        prog_slot(3, 32'h0000_3001, 2'b11, 1'b1, 1'b1);

        // Table walk: R2 lengths, R3 alignment, R4 overlap, R5 condition
        for (int i = 0; i < NVEC; i++) begin
            clear_status(4'b0000);
            access(VEC[i][38:7], VEC[i][6:5], VEC[i][4]);
            check($sformatf("R4 vector %0d status", i), 32'(hit_status), 32'(VEC[i][3:0]));
            check($sformatf("R9 vector %0d trap", i), 32'(trap), 32'(VEC[i][3:0] != 4'b0));
        end

        // R9: the pulse lasts one cycle
        clear_status(4'b0000);
        access(32'h0000_1000, 2'd0, 1'b1);
        check("R9 trap rises", 32'(trap), 32'h1);
        @(negedge clk);
        check("R9 trap one cycle", 32'(trap), 32'h0);
        // R9: repeat hit on an already-set bit gives no trap
        access(32'h0000_1001, 2'd0, 1'b0);
        check("R9 no trap on old bit", 32'(trap), 32'h0);
        check("R7 status sticky", 32'(hit_status), 32'h1);

        // R7: two slots in one access (slot 2 moved over slot 0's region)
        prog_slot(2, 32'h0000_1001, 2'b00, 1'b0, 1'b1);
        clear_status(4'b0000);
        access(32'h0000_1001, 2'd0, 1'b1);
        check("R7 two slots at once", 32'(hit_status), 32'h5);
        access(32'h0000_5000, 2'd0, 1'b1);
        check("R7 bits held with no hit", 32'(hit_status), 32'h5);

        // R8: selective clear
        clear_status(4'b0100);
        check("R8 keep mask", 32'(hit_status), 32'h4);
        // R8: a clear and a hit in one cycle, the hit wins
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'd4; cfg_keep = 4'b0000;
        acc_valid = 1'b1; acc_addr = 32'h0000_1002; acc_size = 2'd0; acc_write = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; acc_valid = 1'b0;
        check("R8 set beats clear", 32'(hit_status), 32'h1);
        check("R8 trap with clear", 32'(trap), 32'h1);

        // R2: the reserved length never matches
        prog_slot(0, 32'h0000_1000, 2'b10, 1'b0, 1'b1);
        clear_status(4'b0000);
        access(32'h0000_1000, 2'd3, 1'b1);
        check("R2 reserved length", 32'(hit_status & 4'b0001), 32'h0);

        // R6: a disabled slot never hits
        prog_slot(0, 32'h0000_1000, 2'b11, 1'b0, 1'b0);
        clear_status(4'b0000);
        access(32'h0000_1000, 2'd0, 1'b1);
        check("R6 disabled slot", 32'(hit_status & 4'b0001), 32'h0);

        // R10: an access in the same cycle as a reprogram uses the old settings
        clear_status(4'b0000);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'd1; cfg_addr = 32'h0000_4000;
        cfg_len = 2'b11; cfg_wonly = 1'b1; cfg_en = 1'b1;
        acc_valid = 1'b1; acc_addr = 32'h0000_1006; acc_size = 2'd0; acc_write = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; acc_valid = 1'b0;
        check("R10 old settings same cycle", 32'(hit_status), 32'h2);
        clear_status(4'b0000);
        access(32'h0000_1006, 2'd0, 1'b1);
        check("R10 old region gone", 32'(hit_status), 32'h0);
        access(32'h0000_4003, 2'd0, 1'b1);
        check("R10 new region live", 32'(hit_status), 32'h2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule